// File: doc/BRIEF.md
# Reloadable Interval Timer

This block is a small interval timer that sits behind a byte-wide register port. Software programs a terminal count with three byte writes and sets a count-enable bit. The counter then starts at zero, climbs by one on each 33 MHz tick, and falls back to zero on the tick after it has reached the terminal count. Each such wrap raises a level interrupt if interrupts are enabled. Software acknowledges the interrupt by clearing the interrupt-enable bit and then setting it again.

The live count is read through four byte registers. A read of offset 0 returns the low bits of the live count and, in the same cycle, copies the whole count into a holding register. Offsets 1 to 3 return the other bits of that copy, so a multi-byte read is coherent. The three lower bytes each carry six count bits, with the sixth bit moved up one position. When the bus clock runs at 66 MHz a mode input halves the tick rate, so the count rate stays at 33 MHz. A build option narrows the counter from 22 to 19 bits.

Top module: `interval_timer`

## Requirements
- R1: With count enable set and the mode input low, the count rises by one on every clock. On the clock after it equals the terminal count it returns to zero, so its period is terminal count plus one. A terminal count of zero keeps it at zero.
- R2: With the mode input high, the count advances on every second clock only. The first advance after enabling comes on the second clock.
- R3: A read of offset 0 copies the live count into a holding register. Reads of offsets 1, 2 and 3 return bytes of that copy, not of the live count.
- R4: In each of offsets 0, 1 and 2, a 6-bit group g of the count is returned as follows: byte bits [4:0] = g[4:0], byte bit 6 = g[5], and byte bits 5 and 7 are zero. Offset 0 holds count bits [5:0] (live), offset 1 bits [11:6] and offset 2 bits [17:12]. Offset 3 returns count bits [21:18] in byte bits [3:0], with its upper bits zero.
- R5: Terminal count writes go to offset 0 for bits [7:0], offset 1 for bits [15:8] and offset 2 for bits [21:16]. Offset 2 uses only write data bits [5:0].
- R6: The control register at offset 4 holds count enable in bit 0 and interrupt enable in bit 1. Both can be written, and a read returns them in bits [1:0] with zeros above.
- R7: While count enable is low, the count is held at zero. A terminal count written in that state applies from the next enable.
- R8: A wrap while interrupt enable is set raises the interrupt output. It stays high until interrupt enable is cleared.
- R9: Clearing interrupt enable drops a pending interrupt. While interrupt enable is low, wraps do not leave a pending interrupt behind. Setting interrupt enable again raises nothing until the next wrap.
- R10: Read data appears on the clock after the read strobe and is held until the next read. Reads of offsets 5 to 7 return zero.
- R11: After reset the count, terminal count, control bits, interrupt and read data are all zero.
- R12: With the narrow option the counter is 19 bits wide. Terminal count bits [21:19] are ignored and count bits [21:19] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, 33 or 66 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_fast | input | 1 | High when the bus clock is 66 MHz; halves the tick rate |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, pending flag gated by interrupt enable |

## Verification
The embedded assertions are checked on every cycle. They cover these rules:
- the count either holds, steps by one or returns to zero;
- the count stays at zero while disabled;
- it never moves on two clocks in a row in 66 MHz mode;
- the holding register captures the pre-edge count on a read of offset 0;
- no interrupt is pending without interrupt enable;
- the interrupt stays high unless acknowledged;
- the padding bits of the readback bytes and the unused offsets read as zero.

Only the bench scenarios can show the other behaviour:
- the count value reached after a given number of clocks, across several terminal counts and both clock modes;
- the exact clock on which the interrupt rises;
- that a later read of offset 1 still returns the earlier snapshot;
- the masking of high write bits;
- the narrow-counter variant.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter bit NARROW = 1'b0,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_fast,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);
  localparam int TW = 22;
  localparam int CW = NARROW ? 19 : 22;

  logic [CW-1:0] count, snap;
  logic [TW-1:0] tc;
  logic          run, ie, pend, half;
  logic [TW-1:0] live_x, snap_x;
  logic [7:0]    rd_mux;

  function automatic logic [7:0] pack6(input logic [5:0] g);
    return {1'b0, g[5], 1'b0, g[4:0]};
  endfunction

  wire tick   = !bus_fast || half;
  wire at_tc  = count >= tc[CW-1:0];
  wire wrap   = run && tick && at_tc;
  wire ctl_wr = wr_en && (addr == AW'(4));
  wire run_d  = ctl_wr ? wdata[0] : run;
  wire ie_d   = ctl_wr ? wdata[1] : ie;

  assign live_x = TW'(count);
  assign snap_x = TW'(snap);
  assign irq    = pend && ie;

  always_comb begin
    case (addr)
      AW'(0):  rd_mux = pack6(live_x[5:0]);
      AW'(1):  rd_mux = pack6(snap_x[11:6]);
      AW'(2):  rd_mux = pack6(snap_x[17:12]);
      AW'(3):  rd_mux = {4'b0, snap_x[21:18]};
      AW'(4):  rd_mux = {6'b0, ie, run};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      snap  <= '0;
      tc    <= '0;
      run   <= 1'b0;
      ie    <= 1'b0;
      pend  <= 1'b0;
      half  <= 1'b0;
      rdata <= 8'h00;
    end else begin
      half <= (run && bus_fast) ? !half : 1'b0;
      if (!run)
        count <= '0;
      else if (tick)
        count <= at_tc ? '0 : count + 1'b1;
      run  <= run_d;
      ie   <= ie_d;
      pend <= ie_d && (pend || (ie && wrap));
      if (wr_en) begin
        case (addr)
          AW'(0):  tc[7:0]   <= wdata;
          AW'(1):  tc[15:8]  <= wdata;
          AW'(2):  tc[21:16] <= wdata[5:0];
          default: ;
        endcase
      end
      if (rd_en && addr == AW'(0))
        snap <= count;
      if (rd_en)
        rdata <= rd_mux;
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 || $stable(count) || count == $past(count) + 1'b1));

  assert_fast_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fast && run && $past(run) && count != $past(count)) |=> $stable(count));

  assert_snap_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(0)) |=> (snap == $past(count)));

  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(addr) < AW'(3)) |-> (rdata[7] == 1'b0 && rdata[5] == 1'b0));

  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctl_wr && !wdata[1])) |=> irq);

  assert_no_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !pend);

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > AW'(4)) |=> (rdata == 8'h00));
endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
  logic clk = 1'b0, rst_n = 1'b0, bus_fast = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, rdata_n;
  logic irq, irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  interval_timer dut (.clk(clk), .rst_n(rst_n), .bus_fast(bus_fast), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));
  interval_timer #(.NARROW(1'b1)) dut_n (.clk(clk), .rst_n(rst_n), .bus_fast(bus_fast),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata_n), .irq(irq_n));

  localparam int NV = 8;
  localparam int V_TC   [NV] = '{3, 3, 100, 0, 1000, 5000, 20, 63};
  localparam int V_FAST [NV] = '{0, 1, 0,   0, 0,    0,    1,  0};
  localparam int V_D    [NV] = '{10, 10, 45, 7, 777, 4500, 101, 100};
  localparam int V_EXP  [NV] = '{2, 1, 45,  0, 777,  4500, 8,  36};

  function automatic logic [7:0] grp(input logic [21:0] v, input int k);
    logic [7:0] b;
    logic [5:0] g;
    b = 8'h00;
    if (k == 3) begin
      b[3:0] = v[21:18];
    end else begin
      g = v[k*6 +: 6];
      b[4:0] = g[4:0];
      b[6] = g[5];
    end
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic set_tc(input logic [21:0] t);
    wr(3'd4, 8'h00);
    wr(3'd0, t[7:0]);
    wr(3'd1, t[15:8]);
    wr(3'd2, {2'b00, t[21:16]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [21:0] e;
    bit seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rdata after reset", rdata, 8'h00);
    chk("R11 irq after reset", irq, 1'b0);
    rd(3'd4, v); chk("R11 control after reset", v, 8'h00);
    rd(3'd0, v); chk("R11 count after reset", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      set_tc(22'(V_TC[i]));
      bus_fast = V_FAST[i][0];
      wr(3'd4, 8'h01);
      repeat (V_D[i]) @(negedge clk);
      e = 22'(V_EXP[i]);
      rd(3'd0, v); chk(V_FAST[i] != 0 ? "R2 vector byte0" : "R1 vector byte0", v, grp(e, 0));
      rd(3'd1, v); chk("R4 vector byte1", v, grp(e, 1));
      rd(3'd2, v); chk("R4 vector byte2", v, grp(e, 2));
      rd(3'd3, v); chk("R4 vector byte3", v, grp(e, 3));
    end
    bus_fast = 1'b0;

    set_tc(22'd5000);
    wr(3'd4, 8'h01);
    repeat (200) @(negedge clk);
    rd(3'd0, v); chk("R3 live low byte", v, 8'h08);
    repeat (100) @(negedge clk);
    rd(3'd1, v); chk("R3 snapshot byte1", v, 8'h03);

    wr(3'd4, 8'h00);
    wr(3'd0, 8'h03); wr(3'd1, 8'h00); wr(3'd2, 8'hC0);
    wr(3'd4, 8'h01);
    repeat (10) @(negedge clk);
    rd(3'd0, v); chk("R5 high bits of byte2 ignored", v, 8'h02);

    wr(3'd4, 8'h00);
    wr(3'd0, 8'h03); wr(3'd1, 8'h00); wr(3'd2, 8'h38);
    wr(3'd4, 8'h01);
    repeat (10) @(negedge clk);
    rd(3'd0, v);
    chk("R12 narrow counter wraps on masked tc", rdata_n, 8'h02);

    wr(3'd4, 8'h00);
    repeat (10) @(negedge clk);
    rd(3'd0, v); chk("R7 disabled count held at zero", v, 8'h00);
    rd(3'd4, v); chk("R6 control readback zero", v, 8'h00);

    set_tc(22'd3);
    wr(3'd4, 8'h03);
    rd(3'd4, v); chk("R6 control readback both bits", v, 8'h03);
    wr(3'd4, 8'h00);
    wr(3'd4, 8'h03);
    repeat (3) @(negedge clk);
    chk("R8 no irq before wrap", irq, 1'b0);
    @(negedge clk);
    chk("R8 irq on wrap", irq, 1'b1);
    repeat (5) @(negedge clk);
    chk("R8 irq stays high", irq, 1'b1);
    wr(3'd4, 8'h01);
    chk("R9 clear ie drops irq", irq, 1'b0);
    wr(3'd4, 8'h03);
    chk("R9 re-arm raises nothing", irq, 1'b0);
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk("R9 irq on next wrap after re-arm", seen, 1'b1);

    wr(3'd4, 8'h01);
    repeat (12) @(negedge clk);
    chk("R9 no irq while ie low", irq, 1'b0);
    wr(3'd4, 8'h03);
    chk("R9 no stale pending after enabling ie", irq, 1'b0);

    rd(3'd5, v); chk("R10 offset 5 reads zero", v, 8'h00);
    rd(3'd6, v); chk("R10 offset 6 reads zero", v, 8'h00);
    rd(3'd7, v); chk("R10 offset 7 reads zero", v, 8'h00);
    rd(3'd4, v);
    repeat (3) @(negedge clk);
    chk("R10 read data held", rdata, 8'h03);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule